// File: doc/BRIEF.md
# Real-Time Clock with Lockable Storage RAM

The block keeps the time of day and the calendar date, advancing once per second from a 32.768 kHz oscillator tick. A prescaler divides the tick down to a one-second pulse. Seconds, minutes, hours, day, month and a two-digit year roll over in cascade. Month lengths and leap years are handled. A register-style host bus reads and writes the clock and alarm fields and a 256-byte general-purpose storage RAM through one flat address space.

Two 8-byte windows of the RAM can be locked for security data. Once a window is locked, reads and writes inside it are refused until power-on reset. The alarm compares seconds, minutes, hours and day of month, so a wake can be scheduled up to about a month ahead. Any alarm field can be made a don't-care.

Two resets model battery-backed state. The system reset `rst_ni` clears only the bus outputs. The power-on reset `por_ni` clears the clock, the alarm and the locks.

Top module: `rtc_lockram`

## Requirements
- R1: The seconds count advances once every PRESC_DIV ticks of `tick_i` (PRESC_DIV defaults to 32768, a 15-bit prescaler). A host write to any time register (0x100 to 0x105) restarts the prescaler, so the next advance comes a full PRESC_DIV ticks after that write.
- R2: On each advance, seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R3: The day wraps to 1 after the last day of the month and carries into the month. Month lengths are 31/28/31/30/31/30/31/31/30/31/30/31 days, and February has 29 days when year mod 4 is 0. Month 12 wraps to 1 and carries into the year, and year 99 wraps to 0.
- R4: With `addr_i[8]` = 0, a request writes `wdata_i` into RAM byte `addr_i[7:0]` or reads it. Read data appears on `rdata_o` on the clock edge that accepts the read and holds until the next read.
- R5: Window w covers the bytes from 8*B to 8*B+7, where B is `win_base_i[5w+4:5w]`. A one-cycle pulse on `lock_i[w]` locks window w, and the lock stays set until power-on reset. The two windows lock independently.
- R6: A read inside a locked window returns 0xFF. A write inside a locked window leaves the RAM unchanged. Either access pulses `err_o` high for one cycle, and no other access raises it.
- R7: `rst_ni` clears only `rdata_o` and `err_o`; the time, alarm fields, alarm flag, locks and RAM keep their values. `por_ni` sets the time to 00:00:00, day 1, month 1, year 0. It also sets the alarm fields to 0xFF with the alarm day at 0, and clears the alarm flag and both locks. It leaves the RAM contents alone.
- R8: After each one-second advance, the alarm flag is set if the new seconds, minutes, hours and day each equal the alarm field at 0x106, 0x107, 0x108 and 0x109 respectively. A field holding 0xFF always matches. The alarm day value 0 never matches. `alarm_o` shows the flag.
- R9: The alarm flag stays set until a host write to 0x10A with bit 0 at 1. A write with bit 0 at 0 leaves it set.
- R10: With `addr_i[8]` = 1, `addr_i[3:0]` selects a register. Index 0 is seconds, 1 minutes, 2 hours, 3 day, 4 month and 5 year. Indexes 6 to 9 are the alarm fields. Index 10 reads the alarm flag in bit 0. All other indexes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset |
| tick_i | input | 1 | 32.768 kHz oscillator tick enable |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | Host write enable |
| addr_i | input | 9 | Host address; bit 8 selects the registers |
| wdata_i | input | 8 | Host write data |
| win_base_i | input | 10 | Window base addresses, 5 bits per window |
| lock_i | input | 2 | Lock set pulses, one per window |
| rdata_o | output | 8 | Registered read data |
| err_o | output | 1 | One-cycle pulse on a refused access |
| alarm_o | output | 1 | Sticky alarm/wake flag |

## Verification
The assertions check on every cycle that the locks never clear and that a refused read returns 0xFF with an error pulse. They also check that the error pulse only follows a refused access, that the alarm flag drops only on a clearing write, and that read data and the seconds count change only after a read, a write or a second pulse. Only the bench scenarios can show the exact rollover results across month ends, leap years and the year wrap. The same holds for prescaler restart timing, alarm matching with don't-care fields, and the RAM contents kept through both resets.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  localparam rtc_time_t TIME_POR = '{sec: 8'd0, min: 8'd0, hour: 8'd0,
                                     day: 8'd1, mon: 8'd1, year: 8'd0};

  localparam logic [3:0] IDX_SEC  = 4'd0;
  localparam logic [3:0] IDX_YEAR = 4'd5;
  localparam logic [3:0] IDX_ASEC = 4'd6;
  localparam logic [3:0] IDX_ADAY = 4'd9;
  localparam logic [3:0] IDX_STAT = 4'd10;
  localparam logic [7:0] DONT_CARE = 8'hFF;

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] year);
    case (mon)
      8'd2:                    return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction

  function automatic logic field_hit(input logic [7:0] alm, input logic [7:0] cur);
    return (alm == DONT_CARE) || (alm == cur);
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk_i,
  input  logic por_ni,
  input  logic tick_i,
  input  logic restart_i,
  output logic pulse_o
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap    = (cnt_q == CW'(DIV - 1));
  assign pulse_o = tick_i && wrap && !restart_i;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       por_ni,
  input  logic       pulse_i,
  input  logic       ld_en_i,
  input  logic [2:0] ld_idx_i,
  input  logic [7:0] ld_data_i,
  output rtc_time_t  time_o
);
  rtc_time_t t_q, t_nxt;

  // cascade; >= recovers from out-of-range host loads
  always_comb begin
    t_nxt = t_q;
    if (t_q.sec >= 8'd59) begin
      t_nxt.sec = '0;
      if (t_q.min >= 8'd59) begin
        t_nxt.min = '0;
        if (t_q.hour >= 8'd23) begin
          t_nxt.hour = '0;
          if (t_q.day >= month_days(t_q.mon, t_q.year)) begin
            t_nxt.day = 8'd1;
            if (t_q.mon >= 8'd12) begin
              t_nxt.mon  = 8'd1;
              t_nxt.year = (t_q.year >= 8'd99) ? 8'd0 : t_q.year + 8'd1;
            end else begin
              t_nxt.mon = t_q.mon + 8'd1;
            end
          end else begin
            t_nxt.day = t_q.day + 8'd1;
          end
        end else begin
          t_nxt.hour = t_q.hour + 8'd1;
        end
      end else begin
        t_nxt.min = t_q.min + 8'd1;
      end
    end else begin
      t_nxt.sec = t_q.sec + 8'd1;
    end
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      t_q <= TIME_POR;
    end else if (ld_en_i) begin
      case (ld_idx_i)
        3'd0:    t_q.sec  <= ld_data_i;
        3'd1:    t_q.min  <= ld_data_i;
        3'd2:    t_q.hour <= ld_data_i;
        3'd3:    t_q.day  <= ld_data_i;
        3'd4:    t_q.mon  <= ld_data_i;
        default: t_q.year <= ld_data_i;
      endcase
    end else if (pulse_i) begin
      t_q <= t_nxt;
    end
  end

  assign time_o = t_q;
endmodule

// File: rtl/rtc_ram_guard.sv
module rtc_ram_guard #(
  parameter int AW        = 8,
  parameter int WIN_BYTES = 8,
  parameter int N_WIN     = 2
) (
  input  logic                             clk_i,
  input  logic                             por_ni,
  input  logic                             req_i,
  input  logic                             we_i,
  input  logic [AW-1:0]                    addr_i,
  input  logic [7:0]                       wdata_i,
  input  logic [N_WIN*(AW-$clog2(WIN_BYTES))-1:0] win_base_i,
  input  logic [N_WIN-1:0]                 lock_set_i,
  output logic [7:0]                       rdata_o,
  output logic                             blocked_o,
  output logic [N_WIN-1:0]                 lock_o
);
  localparam int LW    = $clog2(WIN_BYTES);
  localparam int BW    = AW - LW;
  localparam int DEPTH = 1 << AW;

  logic [7:0]       mem_q [DEPTH];
  logic [N_WIN-1:0] hit;
  logic [N_WIN-1:0] lock_q;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    assign hit[w] = (addr_i[AW-1:LW] == win_base_i[w*BW +: BW]);
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) lock_q <= '0;
    else         lock_q <= lock_q | lock_set_i;
  end

  assign blocked_o = |(hit & lock_q);

  // storage models battery-backed RAM: no reset
  always_ff @(posedge clk_i) begin
    if (req_i && we_i && !blocked_o) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
  assign lock_o  = lock_q;
endmodule

// File: rtl/rtc_lockram.sv
module rtc_lockram
  import rtc_pkg::*;
#(
  parameter int PRESC_DIV = 32768,
  parameter int RAM_AW    = 8,
  parameter int WIN_BYTES = 8,
  parameter int N_WIN     = 2,
  localparam int BASE_W   = RAM_AW - $clog2(WIN_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    por_ni,
  input  logic                    tick_i,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [RAM_AW:0]         addr_i,
  input  logic [7:0]              wdata_i,
  input  logic [N_WIN*BASE_W-1:0] win_base_i,
  input  logic [N_WIN-1:0]        lock_i,
  output logic [7:0]              rdata_o,
  output logic                    err_o,
  output logic                    alarm_o
);
  logic             reg_sel, ram_req, reg_wr, time_wr, alm_wr, stat_clr;
  logic [3:0]       idx;
  logic             sec_pulse, alm_chk_q, alarm_q, alm_match;
  logic [7:0]       ram_rd, reg_rd;
  logic             ram_blocked;
  logic [N_WIN-1:0] lock_w;
  logic [3:0][7:0]  alm_q;
  logic [7:0]       rdata_q;
  logic             err_q;
  rtc_time_t        cal_time;

  assign reg_sel  = addr_i[RAM_AW];
  assign idx      = addr_i[3:0];
  assign ram_req  = req_i && !reg_sel;
  assign reg_wr   = req_i && we_i && reg_sel;
  assign time_wr  = reg_wr && (idx <= IDX_YEAR);
  assign alm_wr   = reg_wr && (idx >= IDX_ASEC) && (idx <= IDX_ADAY);
  assign stat_clr = reg_wr && (idx == IDX_STAT) && wdata_i[0];

  rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk_i     (clk_i),
    .por_ni    (por_ni),
    .tick_i    (tick_i),
    .restart_i (time_wr),
    .pulse_o   (sec_pulse)
  );

  rtc_calendar u_cal (
    .clk_i     (clk_i),
    .por_ni    (por_ni),
    .pulse_i   (sec_pulse),
    .ld_en_i   (time_wr),
    .ld_idx_i  (idx[2:0]),
    .ld_data_i (wdata_i),
    .time_o    (cal_time)
  );

  rtc_ram_guard #(.AW(RAM_AW), .WIN_BYTES(WIN_BYTES), .N_WIN(N_WIN)) u_ram (
    .clk_i      (clk_i),
    .por_ni     (por_ni),
    .req_i      (ram_req),
    .we_i       (we_i),
    .addr_i     (addr_i[RAM_AW-1:0]),
    .wdata_i    (wdata_i),
    .win_base_i (win_base_i),
    .lock_set_i (lock_i),
    .rdata_o    (ram_rd),
    .blocked_o  (ram_blocked),
    .lock_o     (lock_w)
  );

  // alarm fields: [0]=sec [1]=min [2]=hour [3]=day; day 0 never matches
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      alm_q <= {8'd0, DONT_CARE, DONT_CARE, DONT_CARE};
    end else if (alm_wr) begin
      alm_q[2'(idx - IDX_ASEC)] <= wdata_i;
    end
  end

  assign alm_match = field_hit(alm_q[0], cal_time.sec)  &&
                     field_hit(alm_q[1], cal_time.min)  &&
                     field_hit(alm_q[2], cal_time.hour) &&
                     field_hit(alm_q[3], cal_time.day);

  // compare one cycle after the pulse, once the new time is registered
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      alm_chk_q <= 1'b0;
      alarm_q   <= 1'b0;
    end else begin
      alm_chk_q <= sec_pulse;
      if (alm_chk_q && alm_match) alarm_q <= 1'b1;
      else if (stat_clr)          alarm_q <= 1'b0;
    end
  end

  always_comb begin
    case (idx)
      4'd0:    reg_rd = cal_time.sec;
      4'd1:    reg_rd = cal_time.min;
      4'd2:    reg_rd = cal_time.hour;
      4'd3:    reg_rd = cal_time.day;
      4'd4:    reg_rd = cal_time.mon;
      4'd5:    reg_rd = cal_time.year;
      4'd6:    reg_rd = alm_q[0];
      4'd7:    reg_rd = alm_q[1];
      4'd8:    reg_rd = alm_q[2];
      4'd9:    reg_rd = alm_q[3];
      4'd10:   reg_rd = {7'd0, alarm_q};
      default: reg_rd = 8'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= ram_req && ram_blocked;
      if (req_i && !we_i) rdata_q <= reg_sel ? reg_rd : (ram_blocked ? 8'hFF : ram_rd);
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
  assign alarm_o = alarm_q;
endmodule

// File: rtl/rtc_lockram_chk.sv
module rtc_lockram_chk #(
  parameter int RAM_AW = 8,
  parameter int N_WIN  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [RAM_AW:0]  addr_i,
  input logic [7:0]       wdata_i,
  input logic [7:0]       rdata_o,
  input logic             err_o,
  input logic             alarm_o,
  input logic [N_WIN-1:0] lock_w,
  input logic             ram_blocked,
  input logic             sec_pulse,
  input logic [7:0]       sec_now
);
  // R6
  blocked_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    req_i && !we_i && !addr_i[RAM_AW] && ram_blocked |=> (rdata_o == 8'hFF) && err_o);

  // R6
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    err_o |-> $past(req_i && !addr_i[RAM_AW] && ram_blocked));

  // R5
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    (lock_w & $past(lock_w)) == $past(lock_w));

  // R9
  alarm_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $past(alarm_o) && !$past(req_i && we_i && addr_i[RAM_AW] && addr_i[3:0] == 4'd10 && wdata_i[0])
    |-> alarm_o);

  // R4
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !$past(req_i && !we_i) |-> $stable(rdata_o));

  // R1
  sec_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !$past(sec_pulse) && !$past(req_i && we_i && addr_i[RAM_AW]) |-> $stable(sec_now));
endmodule

bind rtc_lockram rtc_lockram_chk #(.RAM_AW(RAM_AW), .N_WIN(N_WIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .por_ni      (por_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .err_o       (err_o),
  .alarm_o     (alarm_o),
  .lock_w      (lock_w),
  .ram_blocked (ram_blocked),
  .sec_pulse   (sec_pulse),
  .sec_now     (cal_time.sec)
);

// File: tb/rtc_lockram_bench.sv
`timescale 1ns/1ps
module rtc_lockram_bench;
  localparam int DIV = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_n = 1'b0;
  logic       tick = 1'b0;
  logic       req = 1'b0;
  logic       we = 1'b0;
  logic [8:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [9:0] win_base = {5'd5, 5'd2};
  logic [1:0] lock = 2'b00;
  logic [7:0] rdata;
  logic       err;
  logic       alarm;

  int checks = 0;
  int errors = 0;

  // {addr, data}; none inside a window
  localparam logic [15:0] VEC [8] = '{16'h00_5A, 16'h07_C3, 16'h18_3E, 16'h3C_01,
                                      16'h80_80, 16'hA5_6D, 16'hFE_7E, 16'hFF_E7};

  rtc_lockram #(.PRESC_DIV(DIV)) u_rtc_lockram (
    .clk_i (clk), .rst_ni (rst_n), .por_ni (por_n), .tick_i (tick),
    .req_i (req), .we_i (we), .addr_i (addr), .wdata_i (wdata),
    .win_base_i (win_base), .lock_i (lock),
    .rdata_o (rdata), .err_o (err), .alarm_o (alarm)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [8:0] a, output logic [7:0] d, output logic e);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata; e = err;
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d, output logic e);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0; e = err;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_time(input int h, input int m, input int s,
                          input int d, input int mo, input int y);
    logic e;
    wr(9'h100, 8'(s), e); wr(9'h101, 8'(m), e); wr(9'h102, 8'(h), e);
    wr(9'h103, 8'(d), e); wr(9'h104, 8'(mo), e); wr(9'h105, 8'(y), e);
  endtask

  task automatic expect_time(input string tag, input int h, input int m, input int s,
                             input int d, input int mo, input int y);
    logic [7:0] v; logic e;
    rd(9'h100, v, e); check({tag, " sec"}, v, s);
    rd(9'h101, v, e); check({tag, " min"}, v, m);
    rd(9'h102, v, e); check({tag, " hour"}, v, h);
    rd(9'h103, v, e); check({tag, " day"}, v, d);
    rd(9'h104, v, e); check({tag, " mon"}, v, mo);
    rd(9'h105, v, e); check({tag, " year"}, v, y);
  endtask

  task automatic pulse_por();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);

    // R7 reset state
    check("R7 rdata after reset", rdata, 0);
    check("R6 err after reset", err, 0);
    check("R8 alarm after reset", alarm, 0);
    expect_time("R7 por time", 0, 0, 0, 1, 1, 0);
    rd(9'h109, v, e); check("R7 alarm day por", v, 0);
    rd(9'h106, v, e); check("R7 alarm sec por", v, 8'hFF);
    rd(9'h10C, v, e); check("R10 unmapped index", v, 0);

    // R4 vector walk
    foreach (VEC[i]) wr({1'b0, VEC[i][15:8]}, VEC[i][7:0], e);
    foreach (VEC[i]) begin
      rd({1'b0, VEC[i][15:8]}, v, e);
      check("R4 ram readback", v, VEC[i][7:0]);
      check("R6 no err outside window", e, 0);
    end

    // R5 R6 locking
    wr(9'h010, 8'h11, e); wr(9'h017, 8'h77, e); wr(9'h028, 8'h28, e);
    @(negedge clk); lock = 2'b01;
    @(negedge clk); lock = 2'b00;
    rd(9'h010, v, e); check("R6 locked read data", v, 8'hFF); check("R6 locked read err", e, 1);
    @(negedge clk); check("R6 err one cycle", err, 0);
    rd(9'h017, v, e); check("R5 window top byte locked", v, 8'hFF);
    rd(9'h018, v, e); check("R5 byte past window", v, 8'h3E); check("R6 err clear", e, 0);
    rd(9'h007, v, e); check("R5 byte below window", v, 8'hC3);
    rd(9'h028, v, e); check("R5 other window open", v, 8'h28);
    wr(9'h010, 8'h22, e); check("R6 locked write err", e, 1);
    @(negedge clk); lock = 2'b10;
    @(negedge clk); lock = 2'b00;
    rd(9'h02F, v, e); check("R5 second window locked", v, 8'hFF); check("R6 err win1", e, 1);
    rd(9'h010, v, e); check("R5 lock held", v, 8'hFF);
    pulse_por();
    rd(9'h010, v, e); check("R6 dropped write, ram kept over por", v, 8'h11);
    check("R7 por clears lock", e, 0);
    rd(9'h02F, v, e); check("R7 por clears lock win1", e, 0);

    // R1 prescaler restart
    set_time(1, 2, 5, 3, 4, 7);
    run_ticks(DIV - 1);
    rd(9'h100, v, e); check("R1 no advance before period", v, 5);
    run_ticks(1);
    rd(9'h100, v, e); check("R1 advance at period", v, 6);
    set_time(1, 2, 10, 3, 4, 7);
    run_ticks(DIV - 1);
    wr(9'h100, 8'd20, e);
    run_ticks(DIV - 1);
    rd(9'h100, v, e); check("R1 restart on write", v, 20);
    run_ticks(1);
    rd(9'h100, v, e); check("R1 full period after write", v, 21);

    // R2 R3 rollovers
    set_time(0, 0, 59, 1, 1, 0);  run_ticks(DIV); expect_time("R2 sec wrap", 0, 1, 0, 1, 1, 0);
    set_time(5, 59, 59, 1, 1, 0); run_ticks(DIV); expect_time("R2 min wrap", 6, 0, 0, 1, 1, 0);
    set_time(23, 59, 59, 28, 2, 3); run_ticks(DIV); expect_time("R3 feb common", 0, 0, 0, 1, 3, 3);
    set_time(23, 59, 59, 28, 2, 4); run_ticks(DIV); expect_time("R3 feb leap", 0, 0, 0, 29, 2, 4);
    set_time(23, 59, 59, 29, 2, 4); run_ticks(DIV); expect_time("R3 leap end", 0, 0, 0, 1, 3, 4);
    set_time(23, 59, 59, 30, 4, 9); run_ticks(DIV); expect_time("R3 30 day month", 0, 0, 0, 1, 5, 9);
    set_time(23, 59, 59, 30, 1, 9); run_ticks(DIV); expect_time("R3 31 day month", 0, 0, 0, 31, 1, 9);
    set_time(23, 59, 59, 31, 12, 99); run_ticks(DIV); expect_time("R3 year wrap", 0, 0, 0, 1, 1, 0);

    // R7 system reset keeps state
    set_time(7, 8, 9, 10, 11, 12);
    wr(9'h040, 8'h99, e);
    rd(9'h040, v, e);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R7 sys reset clears rdata", rdata, 0);
    rst_n = 1'b1;
    expect_time("R7 time kept", 7, 8, 9, 10, 11, 12);
    rd(9'h040, v, e); check("R7 ram kept", v, 8'h99);

    // R8 R9 alarm
    set_time(10, 20, 30, 5, 1, 0);
    wr(9'h106, 8'd31, e); wr(9'h107, 8'd20, e); wr(9'h108, 8'hFF, e); wr(9'h109, 8'd5, e);
    wr(9'h100, 8'd30, e);
    check("R8 no alarm before match", alarm, 0);
    run_ticks(DIV);
    check("R8 alarm on match", alarm, 1);
    rd(9'h10A, v, e); check("R10 status flag", v, 1);
    wr(9'h10A, 8'h00, e);
    rd(9'h10A, v, e); check("R9 write 0 keeps flag", v, 1);
    wr(9'h10A, 8'h01, e);
    check("R9 write 1 clears", alarm, 0);
    run_ticks(DIV);
    check("R8 no repeat on mismatch", alarm, 0);
    wr(9'h109, 8'd6, e); wr(9'h106, 8'hFF, e);
    run_ticks(DIV);
    check("R8 day mismatch blocks", alarm, 0);
    set_time(23, 59, 59, 5, 1, 0);
    wr(9'h106, 8'd0, e); wr(9'h107, 8'd0, e); wr(9'h108, 8'd0, e);
    run_ticks(DIV);
    check("R8 day match after rollover", alarm, 1);
    pulse_por();
    check("R7 por clears alarm", alarm, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule